// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block gathers up to 32 interrupt inputs and forwards them to a processor on a single active-low request line. Each input has its own configuration word. The word chooses how the input is read: high level, low level, rising edge or falling edge. It also gives the input a 3-bit priority. A mask register sets which inputs may raise the request. It is changed through two command words, one that sets bits and one that clears them. Software can also force an input pending, or clear it, through a second pair of command words.

The processor services an interrupt in three steps. It reads the acknowledge register, which returns the winning source number multiplied by four. That read takes the source into service and releases the request line. When the handler is done, the processor writes the end-of-service register. This re-arms arbitration so that the next pending source can raise the line again. Only one service level exists: while a source is in service, no other source can raise the request. Status words show the raw inputs, the decoded pending set and the pending set after masking.

Top module: `prio_vec_intc`

## Requirements
- R1: After synchronous reset the mask is all zero, every configuration word reads 0, the source-number register reads 0 and irq_n is 1.
- R2: The configuration word of source n is at byte address 4*n. Bits [7:6] select the trigger: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. Bits [2:0] hold the priority. Reads return those fields with every other bit 0.
- R3: A high-level source is pending while its input is 1, and a low-level source while its input is 0. Address 0x104 shows the pending set, one bit per source. Address 0x100 shows the raw inputs.
- R4: An edge source becomes pending on the clock edge at which its selected transition is seen. It stays pending after the input returns, until it is acknowledged or soft-cleared.
- R5: Writing 0x120 sets every mask bit whose data bit is 1. Writing 0x124 clears every mask bit whose data bit is 1. Zero bits have no effect in either case. Address 0x114 reads the mask, and 0x108 reads pending AND mask.
- R6: When some unmasked source is pending and no source is in service, irq_n goes to 0 at the next clock edge.
- R7: Arbitration picks the highest priority, with 7 as the highest. Among equal priorities the lowest source number wins. A read of 0x10C returns the winner times four, or 0 when no unmasked source is pending.
- R8: A read of 0x10C while a source wins and none is in service takes that source into service. irq_n returns to 1 at that clock edge and stays 1 until service ends. Address 0x110 then reads the plain source number. The acknowledge also clears that source's edge and soft pending state.
- R9: Any write to 0x130 ends service. If an unmasked source is still pending, irq_n goes to 0 again one clock edge later.
- R10: Writing 0x128 soft-sets pending for each source whose data bit is 1, whatever its input. Writing 0x12C removes the soft and edge pending state of each source whose data bit is 1.
- R11: Address 0x118 bit 0 reads 1 exactly when irq_n is 0. Addresses not assigned to any register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Interrupt source inputs |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, acted on at the clock edge |
| bus_rd | input | 1 | Read strobe, whose side effects act at the clock edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Some rules are checked by the assertions on every cycle. The request line stays released whenever a source is in service. The mask only gains or loses the bits named by the command data. An edge source latches on the edge it selects. The winning source is always one that is requesting. Other behaviour can only be shown by the bench scenarios. These cover the order of winners under mixed priorities and ties, and the exact edge on which the line falls again after end-of-service. They also cover a return value of zero once every input has gone quiet, and the way a soft-cleared or acknowledged edge source drops out of the masked status.

// File: rtl/pvi_pkg.sv
package pvi_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    localparam int PRIO_W = 3;

    typedef struct packed {
        trig_e              trig;
        logic [PRIO_W-1:0]  prio;
    } src_cfg_t;

    localparam int OFF_RAW   = 'h100;
    localparam int OFF_ACT   = 'h104;
    localparam int OFF_MSKD  = 'h108;
    localparam int OFF_PENC  = 'h10C;
    localparam int OFF_SNUM  = 'h110;
    localparam int OFF_MASK  = 'h114;
    localparam int OFF_OUT   = 'h118;
    localparam int OFF_MEN   = 'h120;
    localparam int OFF_MDIS  = 'h124;
    localparam int OFF_SSET  = 'h128;
    localparam int OFF_SCLR  = 'h12C;
    localparam int OFF_EOS   = 'h130;

    function automatic logic is_level(trig_e t);
        return (t == TRIG_LOW) || (t == TRIG_HIGH);
    endfunction

endpackage

// File: rtl/pvi_src_cell.sv
module pvi_src_cell
    import pvi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src,
    input  trig_e trig,
    input  logic  soft_set,
    input  logic  soft_clr,
    input  logic  ack,
    output logic  pend
);
    logic prev_q, edge_q, soft_q;
    logic edge_hit;

    always_comb begin
        unique case (trig)
            TRIG_RISE: edge_hit = src && !prev_q;
            TRIG_FALL: edge_hit = !src && prev_q;
            default:   edge_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            edge_q <= 1'b0;
            soft_q <= 1'b0;
        end else begin
            prev_q <= src;
            if (edge_hit)
                edge_q <= 1'b1;
            else if (ack || soft_clr)
                edge_q <= 1'b0;
            if (soft_set)
                soft_q <= 1'b1;
            else if (ack || soft_clr)
                soft_q <= 1'b0;
        end
    end

    always_comb begin
        if (is_level(trig))
            pend = ((trig == TRIG_HIGH) ? src : !src) || soft_q;
        else
            pend = edge_q || soft_q;
    end

    // R4: the selected edge latches pending on the following cycle
    a_r4_edge_latch: assert property (@(posedge clk) disable iff (rst)
        (trig == TRIG_RISE && src && !prev_q) |=> edge_q);

    // R10: soft set always leaves the soft bit on
    a_r10_soft_set: assert property (@(posedge clk) disable iff (rst)
        soft_set |=> soft_q);

endmodule

// File: rtl/pvi_arbiter.sv
module pvi_arbiter
    import pvi_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int IW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]   req,
    input  logic [PRIO_W-1:0] prio [NSRC],
    output logic              any,
    output logic [IW-1:0]     win
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i] && (!any || prio[i] >= best)) begin
                any  = 1'b1;
                win  = IW'(i);
                best = prio[i];
            end
        end
    end

    // R7: the chosen source is always one that requests
    always_comb begin
        if (any)
            a_r7_win_requests: assert (req[win]);
        else
            a_r7_idle_empty: assert (req == '0);
    end

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pvi_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 9,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_n
);
    localparam int IW = $clog2(NSRC);
    localparam logic [AW-1:0] A_CFG_END = AW'(NSRC * 4);

    src_cfg_t          cfg_q [NSRC];
    logic [PRIO_W-1:0] prio_v [NSRC];
    logic [NSRC-1:0]   mask_q, pend, req;
    logic              in_service_q, irq_q;
    logic [IW-1:0]     cur_q, win;
    logic              any;

    logic              cfg_hit;
    logic [IW-1:0]     cfg_idx;
    logic              wr_men, wr_mdis, wr_sset, wr_sclr, wr_eos, ack_fire;
    logic [NSRC-1:0]   wd_src;

    assign cfg_hit  = (bus_addr < A_CFG_END) && (bus_addr[1:0] == 2'b00);
    assign cfg_idx  = bus_addr[IW+1:2];
    assign wd_src   = bus_wdata[NSRC-1:0];
    assign wr_men   = bus_wr && (bus_addr == AW'(OFF_MEN));
    assign wr_mdis  = bus_wr && (bus_addr == AW'(OFF_MDIS));
    assign wr_sset  = bus_wr && (bus_addr == AW'(OFF_SSET));
    assign wr_sclr  = bus_wr && (bus_addr == AW'(OFF_SCLR));
    assign wr_eos   = bus_wr && (bus_addr == AW'(OFF_EOS));
    assign ack_fire = bus_rd && (bus_addr == AW'(OFF_PENC)) && any && !in_service_q;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign prio_v[i] = cfg_q[i].prio;
            pvi_src_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .src      (src_in[i]),
                .trig     (cfg_q[i].trig),
                .soft_set (wr_sset && wd_src[i]),
                .soft_clr (wr_sclr && wd_src[i]),
                .ack      (ack_fire && (win == IW'(i))),
                .pend     (pend[i])
            );
        end
    endgenerate

    assign req = pend & mask_q;

    pvi_arbiter #(.NSRC(NSRC)) u_arb (
        .req  (req),
        .prio (prio_v),
        .any  (any),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSRC; i++)
                cfg_q[i] <= '{trig: TRIG_LOW, prio: '0};
            mask_q       <= '0;
            in_service_q <= 1'b0;
            cur_q        <= '0;
            irq_q        <= 1'b0;
        end else begin
            if (bus_wr && cfg_hit)
                cfg_q[cfg_idx] <= '{trig: trig_e'(bus_wdata[7:6]), prio: bus_wdata[PRIO_W-1:0]};
            if (wr_men)
                mask_q <= mask_q | wd_src;
            else if (wr_mdis)
                mask_q <= mask_q & ~wd_src;
            if (ack_fire) begin
                in_service_q <= 1'b1;
                cur_q        <= win;
            end else if (wr_eos) begin
                in_service_q <= 1'b0;
            end
            irq_q <= any && !in_service_q && !ack_fire;
        end
    end

    assign irq_n = !irq_q;

    always_comb begin
        bus_rdata = '0;
        if (cfg_hit) begin
            bus_rdata[7:6]        = cfg_q[cfg_idx].trig;
            bus_rdata[PRIO_W-1:0] = cfg_q[cfg_idx].prio;
        end else begin
            unique case (int'(bus_addr))
                OFF_RAW:  bus_rdata[NSRC-1:0] = src_in;
                OFF_ACT:  bus_rdata[NSRC-1:0] = pend;
                OFF_MSKD: bus_rdata[NSRC-1:0] = req;
                OFF_PENC: bus_rdata           = any ? DW'({win, 2'b00}) : '0;
                OFF_SNUM: bus_rdata           = DW'(cur_q);
                OFF_MASK: bus_rdata[NSRC-1:0] = mask_q;
                OFF_OUT:  bus_rdata[0]        = irq_q;
                default:  bus_rdata           = '0;
            endcase
        end
    end

    // R8: no request while a source is in service
    a_r8_quiet_in_service: assert property (@(posedge clk) disable iff (rst)
        in_service_q |-> irq_n);

    // R5: enable command leaves every named bit set
    a_r5_mask_set: assert property (@(posedge clk) disable iff (rst)
        wr_men |=> ((mask_q & $past(wd_src)) == $past(wd_src)));

    // R5: disable command leaves every named bit clear
    a_r5_mask_clr: assert property (@(posedge clk) disable iff (rst)
        wr_mdis |=> ((mask_q & $past(wd_src)) == '0));

    // R6: a request only follows a cycle with an eligible source
    a_r6_req_has_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> ($past(any) && !$past(in_service_q)));

    // R9: end-of-service without acknowledge closes service
    a_r9_eos_closes: assert property (@(posedge clk) disable iff (rst)
        (wr_eos && !ack_fire) |=> !in_service_q);

endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] src_in;
    logic [8:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_vec_intc u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // {source, data written, expected read-back}
    localparam logic [47:0] VEC [6] = '{
        {8'd0,  32'hFFFF_FFFF, 8'hC7},
        {8'd5,  32'h0000_0041, 8'h41},
        {8'd31, 32'h0000_0085, 8'h85},
        {8'd12, 32'h0000_003A, 8'h02},
        {8'd7,  32'h0000_01FF, 8'hC7},
        {8'd20, 32'h0000_0080, 8'h80}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; src_in = '0;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; src_in = '0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        do_reset();

        // R1 reset state
        chk("R1 irq_n", {31'b0, irq_n}, 32'd1);
        rd(9'h114, d); chk("R1 mask", d, 32'h0);
        rd(9'h000, d); chk("R1 cfg", d, 32'h0);
        rd(9'h110, d); chk("R1 srcnum", d, 32'h0);

        // R2 configuration words via vector table
        for (int i = 0; i < 6; i++) begin
            wr({VEC[i][47:40], 2'b00}, VEC[i][39:8]);
            rd({VEC[i][47:40], 2'b00}, d);
            chk("R2 cfg readback", d, {24'b0, VEC[i][7:0]});
        end

        // R3 level decode
        do_reset();
        wr(9'h00C, 32'h40);
        src_in = 32'h18;
        rd(9'h104, d); chk("R3 active", d, 32'hFFFF_FFEF);
        rd(9'h100, d); chk("R3 raw", d, 32'h18);

        // R5 mask commands
        wr(9'h120, 32'h18);
        wr(9'h120, 32'h100);
        wr(9'h124, 32'h8);
        rd(9'h114, d); chk("R5 mask", d, 32'h110);
        rd(9'h108, d); chk("R5 masked", d, 32'h100);

        // R6 request, R11 output status
        chk("R6 irq low", {31'b0, irq_n}, 32'd0);
        rd(9'h118, d); chk("R11 out status", d, 32'h1);
        rd(9'h1FC, d); chk("R11 unassigned", d, 32'h0);

        // R8 acknowledge
        rd(9'h10C, d); chk("R8 ack value", d, 32'h20);
        chk("R8 irq released", {31'b0, irq_n}, 32'd1);
        idle(3);
        chk("R8 irq held off", {31'b0, irq_n}, 32'd1);
        rd(9'h110, d); chk("R8 srcnum", d, 32'd8);

        // R9 end of service
        wr(9'h130, 32'h0);
        chk("R9 still high", {31'b0, irq_n}, 32'd1);
        idle(1);
        chk("R9 rearmed", {31'b0, irq_n}, 32'd0);

        // R7 priority and ties
        do_reset();
        wr(9'h008, 32'h43);
        wr(9'h024, 32'h46);
        wr(9'h044, 32'h46);
        wr(9'h078, 32'h41);
        src_in = 32'h4002_0204;
        wr(9'h120, 32'h4002_0204);
        rd(9'h10C, d); chk("R7 tie lowest", d, 32'd36);
        wr(9'h130, 32'h0);
        src_in[9] = 1'b0;
        rd(9'h10C, d); chk("R7 next", d, 32'd68);
        wr(9'h130, 32'h0);
        src_in[17] = 1'b0;
        rd(9'h10C, d); chk("R7 higher prio", d, 32'd8);
        wr(9'h130, 32'h0);
        src_in = '0;
        rd(9'h10C, d); chk("R7 none", d, 32'd0);
        rd(9'h110, d); chk("R7 srcnum kept", d, 32'd2);

        // R4 edge sources
        do_reset();
        wr(9'h014, 32'hC4);
        wr(9'h018, 32'h80);
        wr(9'h120, 32'h60);
        src_in[5] = 1'b1; idle(1); src_in[5] = 1'b0;
        rd(9'h108, d); chk("R4 rise latched", d, 32'h20);
        rd(9'h10C, d); chk("R4 ack value", d, 32'd20);
        rd(9'h108, d); chk("R4 ack clears", d, 32'h0);
        wr(9'h130, 32'h0);
        src_in[6] = 1'b1; idle(1); src_in[6] = 1'b0; idle(1);
        rd(9'h108, d); chk("R4 fall latched", d, 32'h40);

        // R10 soft set / clear
        do_reset();
        wr(9'h028, 32'h47);
        wr(9'h120, 32'h400);
        wr(9'h128, 32'h400);
        rd(9'h108, d); chk("R10 soft set", d, 32'h400);
        wr(9'h12C, 32'h400);
        rd(9'h108, d); chk("R10 soft clear", d, 32'h0);
        wr(9'h128, 32'h400);
        rd(9'h10C, d); chk("R10 ack value", d, 32'd40);
        rd(9'h108, d); chk("R10 ack clears", d, 32'h0);
        rd(9'h110, d); chk("R10 srcnum", d, 32'd10);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule